// File: doc/BRIEF.md
# Per-CPU Masked Level Interrupt Aggregator

The block gathers a parameterised number of level-sensitive interrupt lines, grouped into 32-bit words, and produces one interrupt request per CPU. Each CPU owns a private set of mask bits. A CPU's request is high while at least one synchronised source is high and not masked for that CPU, so the same source can reach one CPU and stay hidden from another.

Software reaches the block through a simple 32-bit register bus. A bank index picks the CPU, and a byte address picks a register within that CPU's bank. Each bank has four groups with one register per word, placed back to back: raw level view, mask view, mask-set port and mask-clear port. Masks change only through the set and clear ports, and only at bit positions written as 1. This lets two agents change different bits without a read-modify-write race.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After reset every mask bit of every CPU is 1, and every CPU request output is 0.
- R2: The byte offset of group g for word w is (g*NWORDS + w)*4. Group 0 is the raw level view, group 1 the mask view, group 2 mask-set and group 3 mask-clear. A bank spans 16*NWORDS bytes.
- R3: Writing to a mask-set register sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: Writing to a mask-clear register clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: Reading group 1, 2 or 3 returns the current mask word of the selected CPU, where 1 means masked.
- R6: Reading group 0 returns the synchronised source levels, and this value is the same for every bank. A write to group 0 changes no mask bit.
- R7: A CPU's request output is high exactly while (levels AND NOT mask) for that CPU is non-zero. The output is registered and follows a change of mask one cycle after the write, and a change of input three cycles after the input edge.
- R8: The mask banks are independent. A write to one bank leaves the masks of every other bank unchanged.
- R9: An address at or beyond 16*NWORDS, or a bank index at or beyond NCPUS, reads as zero and has no effect when written.
- R10: Reads complete one cycle after the request. rd_valid pulses for one cycle together with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32*NWORDS | Asynchronous level interrupt sources |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_bank | input | BANK_W | CPU bank index |
| bus_addr | input | ADDR_W | Byte address inside the bank |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read-completion pulse |
| cpu_irq | output | NCPUS | Per-CPU interrupt request |

## Verification
The bench drives source levels and masks as patterns: a single lone bit, alternating bits, all ones, and sources placed in the upper word. Each pattern is checked against each CPU's unmasked subset. A pending bit that a mask hides shows that the AND-NOT works. A source that reaches only one CPU shows that the banks are independent. A partial set or clear written over a mixed mask shows that only bits written as 1 change. Out-of-range bank and address accesses, together with writes to the level view, show that all of them leave the mask views unchanged.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;
    typedef enum logic [1:0] {
        GRP_LEVEL = 2'd0,
        GRP_MASK  = 2'd1,
        GRP_SET   = 2'd2,
        GRP_CLR   = 2'd3
    } grp_e;

    typedef struct packed {
        logic       hit;
        grp_e       grp;
        logic [2:0] word;
    } dec_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
    parameter int NWORDS = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output irq_fanout_pkg::dec_t dec
);
    import irq_fanout_pkg::*;
    localparam int NREG = 4 * NWORDS;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        idx      = addr >> 2;
        dec      = '0;
        dec.hit  = (addr[1:0] == 2'b00) && (int'(idx) < NREG);
        dec.grp  = GRP_LEVEL;
        dec.word = '0;
        for (int g = 0; g < 4; g++) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (int'(idx) == g * NWORDS + w) begin
                    dec.grp  = grp_e'(g);
                    dec.word = 3'(w);
                end
            end
        end
    end
endmodule

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end
    assign dout = s2_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int NWORDS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_set,
    input  logic                 wr_clr,
    input  logic [2:0]           word,
    input  logic [31:0]          wdata,
    input  logic [32*NWORDS-1:0] level,
    output logic [32*NWORDS-1:0] mask,
    output logic                 irq
);
    localparam int NB = 32 * NWORDS;

    typedef struct packed {
        logic [NB-1:0] mask;
        logic          irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NWORDS; w++) begin
            if (wr_set && int'(word) == w)
                st_d.mask[w*32 +: 32] = st_q.mask[w*32 +: 32] | wdata;
            if (wr_clr && int'(word) == w)
                st_d.mask[w*32 +: 32] = st_q.mask[w*32 +: 32] & ~wdata;
        end
        st_d.irq = |(level & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
    assign irq  = st_q.irq;

    p_set_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr) |=> (($past(mask) & ~mask) == '0));
    p_clr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> ((~$past(mask) & mask) == '0));
    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(mask));
endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl #(
    parameter int NWORDS = 2,
    parameter int NCPUS  = 2,
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [32*NWORDS-1:0] irq_src,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [BANK_W-1:0]    bus_bank,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    output logic [NCPUS-1:0]     cpu_irq
);
    import irq_fanout_pkg::*;
    localparam int NB = 32 * NWORDS;

    dec_t          dec;
    logic [NB-1:0] level;
    logic [NB-1:0] masks [NCPUS];
    logic          bank_ok;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_t;
    rd_t rd_d, rd_q;

    irq_addr_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .dec(dec));
    irq_sync2 #(.W(NB)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_src), .dout(level));

    assign bank_ok = int'(bus_bank) < NCPUS;

    generate
        for (genvar c = 0; c < NCPUS; c++) begin : g_cpu
            logic sel;
            assign sel = bus_req && bus_we && dec.hit && bank_ok
                         && int'(bus_bank) == c;
            irq_mask_bank #(.NWORDS(NWORDS)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .wr_set(sel && dec.grp == GRP_SET),
                .wr_clr(sel && dec.grp == GRP_CLR),
                .word(dec.word), .wdata(bus_wdata),
                .level(level), .mask(masks[c]), .irq(cpu_irq[c]));
        end
    endgenerate

    always_comb begin
        rd_d        = '0;
        rd_d.rvalid = bus_req && !bus_we;
        if (bus_req && !bus_we && dec.hit && bank_ok) begin
            for (int c = 0; c < NCPUS; c++) begin
                if (int'(bus_bank) == c) begin
                    if (dec.grp == GRP_LEVEL)
                        rd_d.rdata = level[dec.word*32 +: 32];
                    else
                        rd_d.rdata = masks[c][dec.word*32 +: 32];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data  = rd_q.rdata;
    assign rd_valid = rd_q.rvalid;

    p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);
    p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !rd_valid);
    p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !bank_ok) |=> (rd_data == '0));
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_irq == '0));
endmodule

// File: tb/irq_fanout_ctrl_test.sv
module irq_fanout_ctrl_test;
    localparam int NW = 2, NC = 2, AW = 8, BW = 2;
    logic clk = 0, rst_n = 0;
    logic [63:0] src = '0;
    logic req = 0, we = 0;
    logic [BW-1:0] bank = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdat;
    logic rv;
    logic [NC-1:0] irq;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_fanout_ctrl #(.NWORDS(NW), .NCPUS(NC), .ADDR_W(AW), .BANK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_req(req), .bus_we(we),
        .bus_bank(bank), .bus_addr(addr), .bus_wdata(wdata),
        .rd_data(rdat), .rd_valid(rv), .cpu_irq(irq));

    function automatic logic [7:0] off(int g, int w);
        return 8'((g * NW + w) * 4);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int b, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1; we = 1; bank = BW'(b); addr = a; wdata = d;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic rd(int b, logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1; we = 0; bank = BW'(b); addr = a;
        @(negedge clk);
        req = 0;
        d = rdat;
        n_run++;
        if (rv !== 1'b1) begin
            n_fail++;
            $display("FAIL R10: rd_valid actual %b expected 1", rv);
        end
    endtask

    typedef struct packed {
        logic [63:0] s;
        logic [63:0] m0;
        logic [63:0] m1;
        logic [1:0]  exp;
    } vec_t;
    localparam vec_t VT [6] = '{
        '{64'h1, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01},
        '{64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 2'b10},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 2'b11},
        '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01},
        '{64'h0, 64'h0, 64'h0, 2'b00}
    };

    logic [31:0] r;
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rd(0, off(1, 0), r); chk("R1 mask0 reset", r, 32'hFFFF_FFFF);
        rd(1, off(1, 1), r); chk("R1 mask1 reset", r, 32'hFFFF_FFFF);

        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < NC; b++) begin
                logic [63:0] m;
                m = (b == 0) ? VT[i].m0 : VT[i].m1;
                for (int w = 0; w < NW; w++) begin
                    wr(b, off(3, w), 32'hFFFF_FFFF);
                    wr(b, off(2, w), m[w*32 +: 32]);
                end
            end
            src = VT[i].s;
            repeat (4) @(negedge clk);
            chk($sformatf("R7 vec %0d irq", i), 32'(irq), 32'(VT[i].exp));
            rd(0, off(0, 1), r); chk("R6 level word1 bank0", r, VT[i].s[63:32]);
            rd(1, off(0, 1), r); chk("R6 level word1 bank1", r, VT[i].s[63:32]);
            rd(1, off(1, 0), r); chk("R5 mask view bank1", r, VT[i].m1[31:0]);
        end

        src = 64'h0000_0001_0000_0000;
        wr(0, off(2, 0), 32'hFFFF_FFFF); wr(0, off(2, 1), 32'hFFFF_FFFF);
        wr(0, off(3, 1), 32'h0000_00F0);
        rd(0, off(2, 1), r); chk("R4 partial clear / R5 via set", r, 32'hFFFF_FF0F);
        wr(0, off(2, 1), 32'h0000_0030);
        rd(0, off(3, 1), r); chk("R3 partial set / R5 via clr", r, 32'hFFFF_FF3F);
        rd(1, off(1, 1), r); chk("R8 other bank untouched", r, 32'h0);
        wr(0, off(3, 1), 32'h1);
        @(negedge clk);
        chk("R7 irq one cycle after clear", 32'(irq[0]), 32'h1);
        wr(0, off(2, 1), 32'h1);
        @(negedge clk);
        chk("R7 irq drop after set", 32'(irq[0]), 32'h0);
        src = 64'h0000_0002_0000_0000;
        wr(0, off(3, 1), 32'h2);
        src = 64'h0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R7 input fall latency 2", 32'(irq[0]), 32'h1);
        @(negedge clk);
        chk("R7 input fall latency 3", 32'(irq[0]), 32'h0);

        wr(0, off(0, 0), 32'h0); wr(0, off(0, 0), 32'hFFFF_FFFF);
        rd(0, off(1, 0), r); chk("R6 write level ignored", r, 32'hFFFF_FFFF);
        wr(2, off(3, 0), 32'hFFFF_FFFF);
        rd(2, off(1, 0), r); chk("R9 bad bank reads 0", r, 32'h0);
        rd(0, off(1, 0), r); chk("R9 bad bank no write", r, 32'hFFFF_FFFF);
        wr(0, 8'd16 * NW, 32'hFFFF_FFFF);
        rd(0, 8'd16 * NW, r); chk("R9 bad addr reads 0", r, 32'h0);
        rd(0, off(1, 0), r); chk("R2 group packing", r, 32'hFFFF_FFFF);

        @(negedge clk);
        chk("R10 rd_valid idle", 32'(rv), 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule